// File: doc/BRIEF.md
# Filter Bytecode Instruction Decoder

This block turns a stream of 64-bit instruction slots for a small packet-filter virtual machine into decoded records, one per instruction. Slots arrive through a valid/ready handshake. Each record leaves through a second valid/ready handshake one cycle after its last slot is accepted. A record carries every field a later execution stage needs: the instruction class, operation code, operand-source bit, load/store mode and access size, both register indices, the signed 16-bit displacement and a 64-bit immediate. It also carries three error flags.

A mode input picks one of two slot layouts. The layouts differ in which nibble of the register byte names the destination and in the byte order of the displacement and immediate. One instruction, the load of a 64-bit constant, spans two consecutive slots. The decoder keeps the first slot inside, emits nothing for it, and builds the constant from the immediate word of each slot.

Top module: `pfvm_insn_decoder`

## Requirements
- R1: A slot is read as bytes, byte k being `in_slot[8k+7:8k]`. Byte 0 is the code byte, and the decoder reports its fields raw for every instruction: class = bits 2:0, operand-source = bit 3, operation = bits 7:4, load/store mode = bits 7:5, access size = bits 4:3.
- R2: With `big_endian` low, register byte 1 gives the source index in bits 7:4 and the destination in bits 3:0. The displacement is {byte 3, byte 2} and the 32-bit immediate is {byte 7, byte 6, byte 5, byte 4}.
- R3: With `big_endian` high, byte 1 gives the destination in bits 7:4 and the source in bits 3:0. The displacement is {byte 2, byte 3} and the immediate is {byte 4, byte 5, byte 6, byte 7}.
- R4: For every single-slot instruction, the 32-bit immediate is sign-extended to the 64-bit `out_imm`.
- R5: A slot with code byte 0x18 (class 000, size 11, mode 000) begins a wide constant load. The decoder emits no record for that slot. It joins it with the next accepted slot into one record that takes its fields from the first slot and whose `out_imm` is {second immediate, first immediate}.
- R6: If the second slot of a wide load has a nonzero code byte, the joined record has `out_illegal` set.
- R7: For classes 000 through 011, load/store modes 100 and 101 set `out_illegal`. Other encodings leave it clear.
- R8: `out_bad_reg` is set when the destination or source index exceeds 10.
- R9: `out_fp_write` is set when the destination index is 10 and the instruction writes its destination. That is the case for classes 100 and 111, class 001, and class 000 with mode 000.
- R10: `in_ready` is high exactly when the output holds no record or the record is being taken. A record held with `out_ready` low stays valid and unchanged. A record appears one cycle after its last slot is accepted.
- R11: While reset is active and after it releases, `out_valid` is low and any half-received wide load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| big_endian | input | 1 | Slot layout select, 1 = big-endian |
| in_valid | input | 1 | Slot present |
| in_ready | output | 1 | Slot accepted this cycle when valid |
| in_slot | input | 64 | Instruction slot |
| out_valid | output | 1 | Decoded record present |
| out_ready | input | 1 | Consumer takes the record |
| out_class | output | 3 | Instruction class |
| out_opcode | output | 4 | Operation field |
| out_src_sel | output | 1 | Operand source, 1 = register |
| out_ls_mode | output | 3 | Load/store mode field |
| out_ls_size | output | 2 | Access size field |
| out_dst | output | 4 | Destination register index |
| out_src | output | 4 | Source register index |
| out_offset | output | 16 | Signed displacement |
| out_imm | output | 64 | Sign-extended or joined immediate |
| out_illegal | output | 1 | Illegal encoding |
| out_bad_reg | output | 1 | Register index above 10 |
| out_fp_write | output | 1 | Write to the frame-pointer register |

## Verification
On every cycle the assertions check the output handshake: a stalled record stays valid and unchanged, and input is blocked while the output is stalled. They also check that the head slot of a wide load produces no output, that a bad second slot marks the joined record illegal, and that the record's flags agree with its own fields: reserved modes, register range and sign extension. Only the bench scenarios can show that each field lands in the right place under both layouts, that the two wide-load halves are joined in the right order, that the frame-pointer flag follows the write rule, and that a reset in the middle of a wide load discards its first half.

// File: rtl/pfvm_dec_pkg.sv
package pfvm_dec_pkg;

  localparam int SLOT_BYTES = 8;
  localparam int SLOT_W     = SLOT_BYTES * 8;
  localparam int CODE_POS   = 0;
  localparam int REGB_POS   = 1;
  localparam int OFF_POS    = 2;
  localparam int OFF_BYTES  = 2;
  localparam int OFF_W      = OFF_BYTES * 8;
  localparam int IMM_POS    = OFF_POS + OFF_BYTES;
  localparam int IMM_BYTES  = 4;
  localparam int IMM_W      = IMM_BYTES * 8;
  localparam int WIDE_W     = 2 * IMM_W;
  localparam int RIDX_W     = 4;

  typedef enum logic [2:0] {
    CLS_LD    = 3'b000,
    CLS_LDX   = 3'b001,
    CLS_ST    = 3'b010,
    CLS_STX   = 3'b011,
    CLS_ALU   = 3'b100,
    CLS_JMP   = 3'b101,
    CLS_JMP32 = 3'b110,
    CLS_ALU64 = 3'b111
  } cls_e;

  typedef enum logic [2:0] {
    LSM_IMM  = 3'b000,
    LSM_ABS  = 3'b001,
    LSM_IND  = 3'b010,
    LSM_MEM  = 3'b011,
    LSM_RSVA = 3'b100,
    LSM_RSVB = 3'b101,
    LSM_XADD = 3'b110,
    LSM_SPR  = 3'b111
  } lsmode_e;

  typedef enum logic [1:0] {
    SZ_WORD = 2'b00,
    SZ_HALF = 2'b01,
    SZ_BYTE = 2'b10,
    SZ_DBL  = 2'b11
  } lssize_e;

  typedef struct packed {
    cls_e              cls;
    logic [3:0]        op;
    logic              src_sel;
    lsmode_e           mode;
    lssize_e           size;
    logic [RIDX_W-1:0] dst;
    logic [RIDX_W-1:0] src;
    logic [OFF_W-1:0]  offset;
    logic [WIDE_W-1:0] imm;
    logic              illegal;
    logic              bad_reg;
    logic              fp_write;
  } dec_rec_t;

endpackage

// File: rtl/pfvm_slot_unpack.sv
module pfvm_slot_unpack
  import pfvm_dec_pkg::*;
(
  input  logic [SLOT_W-1:0] slot,
  input  logic              big_endian,
  output logic [7:0]        code,
  output logic [RIDX_W-1:0] dst,
  output logic [RIDX_W-1:0] src,
  output logic [OFF_W-1:0]  offset,
  output logic [IMM_W-1:0]  imm32
);

  logic [7:0] byte_a [SLOT_BYTES];
  logic [7:0] reg_byte;

  generate
    for (genvar i = 0; i < SLOT_BYTES; i++) begin : g_bytes
      assign byte_a[i] = slot[8*i +: 8];
    end

    // displacement: byte order follows the layout mode
    for (genvar k = 0; k < OFF_BYTES; k++) begin : g_off
      assign offset[8*k +: 8] = big_endian ? byte_a[OFF_POS + OFF_BYTES - 1 - k]
                                           : byte_a[OFF_POS + k];
    end

    for (genvar k = 0; k < IMM_BYTES; k++) begin : g_imm
      assign imm32[8*k +: 8] = big_endian ? byte_a[IMM_POS + IMM_BYTES - 1 - k]
                                          : byte_a[IMM_POS + k];
    end
  endgenerate

  assign code     = byte_a[CODE_POS];
  assign reg_byte = byte_a[REGB_POS];
  assign dst      = big_endian ? reg_byte[7:4] : reg_byte[3:0];
  assign src      = big_endian ? reg_byte[3:0] : reg_byte[7:4];

endmodule

// File: rtl/pfvm_legal_check.sv
module pfvm_legal_check
  import pfvm_dec_pkg::*;
#(
  parameter int LAST_REG = 10,
  parameter int FP_REG   = 10
) (
  input  logic [7:0]        code,
  input  logic [RIDX_W-1:0] dst,
  input  logic [RIDX_W-1:0] src,
  output logic              illegal_mode,
  output logic              bad_reg,
  output logic              fp_write,
  output logic              wide_head
);

  localparam logic [RIDX_W-1:0] LAST_IDX = RIDX_W'(LAST_REG);
  localparam logic [RIDX_W-1:0] FP_IDX   = RIDX_W'(FP_REG);
  localparam logic [7:0] WIDE_CODE = {LSM_IMM, SZ_DBL, CLS_LD};

  cls_e    cls;
  lsmode_e mode;
  logic    is_mem_class;
  logic    writes_dst;

  assign cls          = cls_e'(code[2:0]);
  assign mode         = lsmode_e'(code[7:5]);
  assign is_mem_class = (cls == CLS_LD) || (cls == CLS_LDX) ||
                        (cls == CLS_ST) || (cls == CLS_STX);

  always_comb begin
    unique case (cls)
      CLS_ALU, CLS_ALU64, CLS_LDX: writes_dst = 1'b1;
      CLS_LD:                      writes_dst = (mode == LSM_IMM);
      default:                     writes_dst = 1'b0;
    endcase
  end

  assign illegal_mode = is_mem_class && ((mode == LSM_RSVA) || (mode == LSM_RSVB));
  assign bad_reg      = (dst > LAST_IDX) || (src > LAST_IDX);
  assign fp_write     = writes_dst && (dst == FP_IDX);
  assign wide_head    = (code == WIDE_CODE);

endmodule

// File: rtl/pfvm_insn_decoder.sv
module pfvm_insn_decoder
  import pfvm_dec_pkg::*;
#(
  parameter int LAST_REG   = 10,
  parameter int FP_REG     = 10,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              big_endian,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SLOT_W-1:0] in_slot,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_class,
  output logic [3:0]        out_opcode,
  output logic              out_src_sel,
  output logic [2:0]        out_ls_mode,
  output logic [1:0]        out_ls_size,
  output logic [RIDX_W-1:0] out_dst,
  output logic [RIDX_W-1:0] out_src,
  output logic [OFF_W-1:0]  out_offset,
  output logic [WIDE_W-1:0] out_imm,
  output logic              out_illegal,
  output logic              out_bad_reg,
  output logic              out_fp_write
);

  // reset: asserted asynchronously, released through a synchronizer
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_ok = rst_pipe[RST_STAGES-1];

  // field extraction and legality
  logic [7:0]        cur_code;
  logic [RIDX_W-1:0] cur_dst;
  logic [RIDX_W-1:0] cur_src;
  logic [OFF_W-1:0]  cur_off;
  logic [IMM_W-1:0]  cur_imm32;
  logic              cur_ill, cur_badr, cur_fpw, cur_wide;

  pfvm_slot_unpack u_unpack (
    .slot       (in_slot),
    .big_endian (big_endian),
    .code       (cur_code),
    .dst        (cur_dst),
    .src        (cur_src),
    .offset     (cur_off),
    .imm32      (cur_imm32)
  );

  pfvm_legal_check #(
    .LAST_REG (LAST_REG),
    .FP_REG   (FP_REG)
  ) u_legal (
    .code         (cur_code),
    .dst          (cur_dst),
    .src          (cur_src),
    .illegal_mode (cur_ill),
    .bad_reg      (cur_badr),
    .fp_write     (cur_fpw),
    .wide_head    (cur_wide)
  );

  dec_rec_t cur_rec, join_rec, rec_n;
  dec_rec_t head_q, out_q;
  logic     pend_q, pend_n;
  logic     out_valid_q, valid_n;
  logic     head_en, out_en, fire;

  always_comb begin
    cur_rec          = '0;
    cur_rec.cls      = cls_e'(cur_code[2:0]);
    cur_rec.op       = cur_code[7:4];
    cur_rec.src_sel  = cur_code[3];
    cur_rec.mode     = lsmode_e'(cur_code[7:5]);
    cur_rec.size     = lssize_e'(cur_code[4:3]);
    cur_rec.dst      = cur_dst;
    cur_rec.src      = cur_src;
    cur_rec.offset   = cur_off;
    cur_rec.imm      = {{(WIDE_W-IMM_W){cur_imm32[IMM_W-1]}}, cur_imm32};
    cur_rec.illegal  = cur_ill;
    cur_rec.bad_reg  = cur_badr;
    cur_rec.fp_write = cur_fpw;
  end

  // wide load: upper word from the second slot, low word kept from the head
  always_comb begin
    join_rec         = head_q;
    join_rec.imm     = {cur_imm32, head_q.imm[IMM_W-1:0]};
    join_rec.illegal = head_q.illegal | (cur_code != '0);
  end

  assign in_ready = rst_ok && (!out_valid_q || out_ready);
  assign fire     = in_valid && in_ready;

  always_comb begin
    pend_n  = pend_q;
    head_en = 1'b0;
    out_en  = 1'b0;
    rec_n   = cur_rec;
    valid_n = out_valid_q && !out_ready;
    if (fire) begin
      if (pend_q) begin
        rec_n  = join_rec;
        out_en = 1'b1;
        pend_n = 1'b0;
      end else if (cur_wide) begin
        head_en = 1'b1;
        pend_n  = 1'b1;
      end else begin
        out_en = 1'b1;
      end
    end
    if (out_en) valid_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      pend_q      <= 1'b0;
      out_valid_q <= 1'b0;
    end else begin
      pend_q      <= pend_n;
      out_valid_q <= valid_n;
    end
  end

  always_ff @(posedge clk) begin
    if (head_en) head_q <= cur_rec;
    if (out_en)  out_q  <= rec_n;
  end

  assign out_valid    = out_valid_q;
  assign out_class    = out_q.cls;
  assign out_opcode   = out_q.op;
  assign out_src_sel  = out_q.src_sel;
  assign out_ls_mode  = out_q.mode;
  assign out_ls_size  = out_q.size;
  assign out_dst      = out_q.dst;
  assign out_src      = out_q.src;
  assign out_offset   = out_q.offset;
  assign out_imm      = out_q.imm;
  assign out_illegal  = out_q.illegal;
  assign out_bad_reg  = out_q.bad_reg;
  assign out_fp_write = out_q.fp_write;

endmodule

// File: rtl/pfvm_insn_decoder_chk.sv
module pfvm_insn_decoder_chk (
  input logic        clk,
  input logic        rst_ok,
  input logic        pend,
  input logic        in_valid,
  input logic        in_ready,
  input logic [7:0]  in_code,
  input logic        out_valid,
  input logic        out_ready,
  input logic [2:0]  out_class,
  input logic [3:0]  out_opcode,
  input logic        out_src_sel,
  input logic [2:0]  out_ls_mode,
  input logic [1:0]  out_ls_size,
  input logic [3:0]  out_dst,
  input logic [3:0]  out_src,
  input logic [15:0] out_offset,
  input logic [63:0] out_imm,
  input logic        out_illegal,
  input logic        out_bad_reg,
  input logic        out_fp_write
);

  logic [111:0] rec_vec;
  logic         fire;
  logic         wide_rec;

  assign rec_vec  = {out_class, out_opcode, out_src_sel, out_ls_mode, out_ls_size,
                     out_dst, out_src, out_offset, out_imm, out_illegal,
                     out_bad_reg, out_fp_write, 8'h00};
  assign fire     = in_valid && in_ready;
  assign wide_rec = (out_class == 3'b000) && (out_ls_mode == 3'b000) && (out_ls_size == 2'b11);

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    out_valid && !out_ready |=> out_valid && $stable(rec_vec)); // R10

  AST_IN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_ok)
    out_valid && !out_ready |-> !in_ready); // R10

  AST_WIDE_SILENT: assert property (@(posedge clk) disable iff (!rst_ok)
    fire && !pend && (in_code == 8'h18) |=> !out_valid); // R5

  AST_SECOND_BAD: assert property (@(posedge clk) disable iff (!rst_ok)
    fire && pend && (in_code != 8'h00) |=> out_valid && out_illegal); // R6

  AST_RSV_MODE: assert property (@(posedge clk) disable iff (!rst_ok)
    out_valid && !out_class[2] && ((out_ls_mode == 3'b100) || (out_ls_mode == 3'b101))
    |-> out_illegal); // R7

  AST_REG_RANGE: assert property (@(posedge clk) disable iff (!rst_ok)
    out_valid && ((out_dst > 4'd10) || (out_src > 4'd10)) |-> out_bad_reg); // R8

  AST_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_ok)
    out_valid && !wide_rec |-> (out_imm[63:32] == {32{out_imm[31]}})); // R4

endmodule

bind pfvm_insn_decoder pfvm_insn_decoder_chk u_chk (
  .clk          (clk),
  .rst_ok       (rst_ok),
  .pend         (pend_q),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_code      (in_slot[7:0]),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_class    (out_class),
  .out_opcode   (out_opcode),
  .out_src_sel  (out_src_sel),
  .out_ls_mode  (out_ls_mode),
  .out_ls_size  (out_ls_size),
  .out_dst      (out_dst),
  .out_src      (out_src),
  .out_offset   (out_offset),
  .out_imm      (out_imm),
  .out_illegal  (out_illegal),
  .out_bad_reg  (out_bad_reg),
  .out_fp_write (out_fp_write)
);

// File: tb/tb_pfvm_insn_decoder.sv
`timescale 1ns/1ps
module tb_pfvm_insn_decoder;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        big_endian;
  logic        in_valid;
  logic        in_ready;
  logic [63:0] in_slot;
  logic        out_valid;
  logic        out_ready;
  logic [2:0]  out_class;
  logic [3:0]  out_opcode;
  logic        out_src_sel;
  logic [2:0]  out_ls_mode;
  logic [1:0]  out_ls_size;
  logic [3:0]  out_dst;
  logic [3:0]  out_src;
  logic [15:0] out_offset;
  logic [63:0] out_imm;
  logic        out_illegal;
  logic        out_bad_reg;
  logic        out_fp_write;

  always #2 clk = ~clk;

  pfvm_insn_decoder dut (
    .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
    .in_valid(in_valid), .in_ready(in_ready), .in_slot(in_slot),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_class(out_class), .out_opcode(out_opcode), .out_src_sel(out_src_sel),
    .out_ls_mode(out_ls_mode), .out_ls_size(out_ls_size),
    .out_dst(out_dst), .out_src(out_src), .out_offset(out_offset),
    .out_imm(out_imm), .out_illegal(out_illegal), .out_bad_reg(out_bad_reg),
    .out_fp_write(out_fp_write)
  );

  int checks = 0;
  int errors = 0;
  logic [103:0] exp_q [$];
  string        tag_q [$];
  logic         b_pend = 1'b0;
  logic [63:0]  head_slot;
  logic         head_be;

  function automatic logic [63:0] mk(input logic [7:0] c, input logic [7:0] r,
                                     input logic [7:0] o0, input logic [7:0] o1,
                                     input logic [7:0] i0, input logic [7:0] i1,
                                     input logic [7:0] i2, input logic [7:0] i3);
    return {i3, i2, i1, i0, o1, o0, r, c};
  endfunction

  function automatic logic [31:0] imm_of(input logic [63:0] s, input logic be);
    return be ? {s[39:32], s[47:40], s[55:48], s[63:56]} : s[63:32];
  endfunction

  // expected record: {class, op, srcsel, mode, size, dst, src, off, imm64, ill, badreg, fpw}
  function automatic logic [103:0] model(input logic [63:0] s, input logic be);
    logic [7:0]  c, r;
    logic [15:0] off;
    logic [31:0] im;
    logic [3:0]  d, sr;
    logic        ill, bad, wr;
    c   = s[7:0];
    r   = s[15:8];
    off = be ? {s[23:16], s[31:24]} : {s[31:24], s[23:16]};
    im  = imm_of(s, be);
    d   = be ? r[7:4] : r[3:0];
    sr  = be ? r[3:0] : r[7:4];
    ill = (c[2:0] < 3'd4) && ((c[7:5] == 3'd4) || (c[7:5] == 3'd5));
    bad = (d > 4'd10) || (sr > 4'd10);
    wr  = (c[2:0] == 3'd4) || (c[2:0] == 3'd7) || (c[2:0] == 3'd1) ||
          ((c[2:0] == 3'd0) && (c[7:5] == 3'd0));
    return {c[2:0], c[7:4], c[3], c[7:5], c[4:3], d, sr, off,
            {{32{im[31]}}, im}, ill, bad, (wr && (d == 4'd10))};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [103:0] act,
                     input logic [103:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] s, input logic be, input string req);
    logic [103:0] e;
    @(negedge clk);
    big_endian = be;
    in_slot    = s;
    in_valid   = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    if (b_pend) begin
      e          = model(head_slot, head_be);
      e[66:3]    = {imm_of(s, be), e[34:3]};
      e[2]       = e[2] | (s[7:0] != 8'h00);
      exp_q.push_back(e);
      tag_q.push_back(req);
      b_pend = 1'b0;
    end else if (s[7:0] == 8'h18) begin
      b_pend    = 1'b1;
      head_slot = s;
      head_be   = be;
    end else begin
      exp_q.push_back(model(s, be));
      tag_q.push_back(req);
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 20 && exp_q.size() != 0; i++) @(negedge clk);
    @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    #1;
    if (rst_n && out_valid && out_ready) begin
      logic [103:0] act;
      act = {out_class, out_opcode, out_src_sel, out_ls_mode, out_ls_size, out_dst,
             out_src, out_offset, out_imm, out_illegal, out_bad_reg, out_fp_write};
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected record", act, '0);
      end else begin
        logic [103:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(act === e, t, act, e);
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R10 watchdog actual=hung expected=complete");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; big_endian = 1'b0; in_slot = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R11 reset out_valid", {103'd0, out_valid}, 104'd0);
    chk(in_ready == 1'b1, "R10 ready after reset", {103'd0, in_ready}, 104'd1);

    // layouts and field split
    send(mk(8'h0f, 8'h21, 8'h34, 8'h12, 8'h78, 8'h56, 8'h34, 8'h12), 1'b0, "R2 le add reg");
    send(mk(8'h0f, 8'h21, 8'h34, 8'h12, 8'h78, 8'h56, 8'h34, 8'h12), 1'b1, "R3 be add reg");
    send(mk(8'h6e, 8'h45, 8'hfe, 8'hff, 8'h01, 8'h00, 8'h00, 8'h00), 1'b0, "R1 jmp32 sgt");
    send(mk(8'h61, 8'h13, 8'h08, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00), 1'b1, "R1 ldx mem word");
    // sign extension
    send(mk(8'h07, 8'h01, 8'h00, 8'h00, 8'hff, 8'hff, 8'hff, 8'h80), 1'b0, "R4 le neg imm");
    send(mk(8'h07, 8'h10, 8'h00, 8'h00, 8'h80, 8'h00, 8'h00, 8'h01), 1'b1, "R4 be neg imm");
    // reserved modes and a legal high-mode alu
    send(mk(8'h91, 8'h12, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00), 1'b0, "R7 mode100 ldx");
    send(mk(8'ha2, 8'h03, 8'h00, 8'h00, 8'h05, 8'h00, 8'h00, 8'h00), 1'b0, "R7 mode101 st");
    send(mk(8'ha4, 8'h02, 8'h00, 8'h00, 8'h0f, 8'h00, 8'h00, 8'h00), 1'b0, "R7 alu not illegal");
    // register range
    send(mk(8'h0f, 8'hb3, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00), 1'b0, "R8 src 11");
    send(mk(8'h0f, 8'h3c, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00), 1'b1, "R8 src 12 be");
    // frame pointer writes
    send(mk(8'hb7, 8'h0a, 8'h00, 8'h00, 8'h07, 8'h00, 8'h00, 8'h00), 1'b0, "R9 mov to r10");
    send(mk(8'h63, 8'h1a, 8'hf8, 8'hff, 8'h00, 8'h00, 8'h00, 8'h00), 1'b0, "R9 store via r10");
    drain();

    // wide loads
    send(mk(8'h18, 8'h03, 8'h00, 8'h00, 8'haa, 8'hbb, 8'hcc, 8'hdd), 1'b0, "R5 wide head");
    repeat (2) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R5 no record for head", {103'd0, out_valid}, 104'd0);
    send(mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h11, 8'h22, 8'h33, 8'h44), 1'b0, "R5 wide le join");
    send(mk(8'h18, 8'h50, 8'h00, 8'h00, 8'h12, 8'h34, 8'h56, 8'h78), 1'b1, "R5 wide head be");
    send(mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h9a, 8'hbc, 8'hde, 8'hf0), 1'b1, "R5 wide be join");
    send(mk(8'h18, 8'h0a, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 8'h00), 1'b0, "R6 wide head");
    send(mk(8'h07, 8'h00, 8'h00, 8'h00, 8'h02, 8'h00, 8'h00, 8'h00), 1'b0, "R6 bad second slot");
    drain();

    // backpressure
    @(negedge clk); out_ready = 1'b0;
    send(mk(8'h1f, 8'h54, 8'h10, 8'h00, 8'h20, 8'h00, 8'h00, 8'h00), 1'b0, "R10 stalled record");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1;
      chk(out_valid == 1'b1, "R10 held valid", {103'd0, out_valid}, 104'd1);
      chk(in_ready == 1'b0, "R10 input blocked", {103'd0, in_ready}, 104'd0);
    end
    @(negedge clk); out_ready = 1'b1;
    drain();

    // reset during a half-received wide load
    send(mk(8'h18, 8'h01, 8'h00, 8'h00, 8'h55, 8'h55, 8'h55, 8'h55), 1'b0, "R11 head");
    @(negedge clk); rst_n = 1'b0; b_pend = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R11 out_valid after reset", {103'd0, out_valid}, 104'd0);
    send(mk(8'h04, 8'h02, 8'h00, 8'h00, 8'h09, 8'h00, 8'h00, 8'h00), 1'b0, "R11 head dropped");
    drain();

    chk(exp_q.size() == 0, "R10 all records delivered", 104'(exp_q.size()), 104'd0);
    summary();
    $finish;
  end

endmodule